// File: doc/BRIEF.md
# NAND Page Data Randomizer

This block whitens the byte stream between a NAND controller's data path and the flash pins. A 15-bit linear feedback shift register makes a pseudo-random sequence. The low byte of the register is XORed onto every passing byte, and the register then moves one step on. Read and write use the same XOR, so one block both scrambles and unscrambles. The starting value depends on the page number, and the sequence is tied to the column, so any byte of a page can be reached on its own. The controller pulses a start with the page, the starting column, the direction and the page layout. The block then moves its generator forward to that column, one step per cycle. While it does so, `in_ready_o` is low.

A page is divided into reseed segments. In the chunked layout each ECC data chunk starts again from the page seed, and the spare groups that follow the data area start from a sub-seed. In the interleaved layout the data part of each unit uses the page seed and the prepad and ECC part uses the sub-seed. Any column outside these regions runs from the page seed. The block computes the sub-seeds once after reset, for every entry of its seed table. When a stream crosses a segment boundary, the block reloads the segment's base value and moves forward again if it has to. On writes in the chunked layout, the first two bytes of each spare group get a fixed mask derived from the sub-seed, so that all-ones user bytes can be produced on the medium.

The control state machine has four states:
- ST_INIT: the block builds the sub-seed table after reset.
- ST_IDLE: no session is open and bytes pass through unchanged.
- ST_SEEK: the generator steps towards the target offset.
- ST_RUN: the block scrambles bytes.

The transitions are:
- init_done: ST_INIT to ST_IDLE, when the table is complete.
- start_seek: from ST_IDLE, ST_SEEK or ST_RUN to ST_SEEK, on a start whose offset is not zero.
- start_run: from the same states to ST_RUN, on a start whose offset is zero.
- seek_done: ST_SEEK to ST_RUN, when the step count runs out.
- reseed_seek: ST_RUN to ST_SEEK, at a segment boundary whose new offset is not zero.
- reseed_run: ST_RUN stays in ST_RUN, at a boundary whose new offset is zero.

Top module: `nand_page_randomizer`

## Requirements
- R1: One generator step puts old bit 0 XOR old bit 1 into bit 14 and shifts bits 14..1 down into bits 13..0. An enabled byte in a session leaves as input XOR bits 7..0 of the state that belongs to its column.
- R2: The page seed is seed-table entry (page mod NUM_SEEDS), with entry i held in SEED_LIST bits [15i+14:15i]. Entry 0 defaults to 0x4A80.
- R3: In the flat layout (layout_i = 0), and in any column outside the structured regions, the state of column c is the page seed advanced (c mod 4096) steps.
- R4: In the chunked layout (layout_i = 1), column c below PAGE_BYTES uses the page seed advanced (c mod ECC_SIZE) steps.
- R5: In the chunked layout, the spare area from PAGE_BYTES is made of groups of ECC_BYTES+4 bytes, one group per chunk. Byte k of a group uses the sub-seed advanced k steps.
- R6: In the interleaved layout (layout_i = 2), units of ECC_SIZE+PREPAD+ECC_BYTES bytes start at column 0, one unit per chunk. Position p of a unit uses the page seed advanced p steps when p < ECC_SIZE, and the sub-seed advanced (p - ECC_SIZE) steps otherwise.
- R7: The sub-seed of each table entry is that seed advanced SUB_STEPS steps. It is computed after reset, and in_ready_o stays low until this is done.
- R8: With write_i = 1 in the chunked layout, bytes 0 and 1 of each spare group are XORed with bits 7..0 of the sub-seed advanced 15 and 16 steps. Reads use the R5 mask.
- R9: After a start, in_ready_o is low for exactly as many cycles as the target offset has steps. Bytes offered in that time produce no output.
- R10: A stream that crosses a segment boundary carries on with the values a fresh start at the new column would give.
- R11: A byte accepted with enable_i low leaves unchanged, and the generator and column do not move.
- R12: Each accepted byte appears on out_data_o with out_valid_o one cycle later. No other cycle raises out_valid_o.
- R13: Before any start, accepted bytes pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a session at column_i of page_i |
| page_i | input | PAGE_W | Page number for the seed choice |
| column_i | input | COL_W | Starting column |
| write_i | input | 1 | 1 = program direction, 0 = read direction |
| layout_i | input | 2 | 0 flat, 1 chunked, 2 interleaved, 3 flat |
| enable_i | input | 1 | Scrambling enable for the offered byte |
| in_valid_i | input | 1 | Byte offered |
| in_data_i | input | 8 | Byte in |
| in_ready_o | output | 1 | Byte accepted when in_valid_i is high and start_i is low |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Scrambled or passed byte |

## Verification
Two functions can fall in the same cycle. When the byte on the last column of a segment is accepted, the XOR for that byte uses the old state, and in the same edge the generator reloads for the next segment. The bench streams through chunk-to-chunk boundaries (zero new offset, so no gap), through group-to-flat boundaries and unit-to-flat boundaries (nonzero offset, so a seek follows). Bytes keep being offered through the seek. Every output byte is compared against a per-column reference that knows nothing of segment tracking, so a byte scrambled with the reloaded state, or a dropped or repeated byte, shows up at once.

// File: rtl/nand_rnd_pkg.sv
package nand_rnd_pkg;
    localparam int LFSR_W = 15;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic [1:0] {
        LAY_FLAT  = 2'd0,
        LAY_CHUNK = 2'd1,
        LAY_INTER = 2'd2,
        LAY_RSVD  = 2'd3
    } layout_e;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_SEEK = 2'd2,
        ST_RUN  = 2'd3
    } rnd_state_e;

    function automatic lfsr_t lfsr_next(lfsr_t s);
        return {s[0] ^ s[1], s[LFSR_W-1:1]};
    endfunction
endpackage

// File: rtl/nand_rnd_seedtab.sv
module nand_rnd_seedtab
    import nand_rnd_pkg::*;
#(
    parameter int NUM_SEEDS = 1,
    parameter logic [NUM_SEEDS*LFSR_W-1:0] SEED_LIST = 15'h4A80,
    parameter int SUB_STEPS = 4096,
    parameter int IDX_W = 1,
    parameter int TAB_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       done_o,
    output lfsr_t      sub_o  [TAB_N],
    output logic [7:0] pre0_o [TAB_N],
    output logic [7:0] pre1_o [TAB_N]
);
    localparam int CNT_W = $clog2(SUB_STEPS + 17) + 1;
    localparam logic [CNT_W-1:0] AT_SUB  = CNT_W'(SUB_STEPS);
    localparam logic [CNT_W-1:0] AT_PRE0 = CNT_W'(SUB_STEPS + 15);
    localparam logic [CNT_W-1:0] AT_PRE1 = CNT_W'(SUB_STEPS + 16);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM_SEEDS - 1);

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    lfsr_t            cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cnt_q  <= '0;
            cur_q  <= SEED_LIST[LFSR_W-1:0];
            done_o <= 1'b0;
            for (int i = 0; i < TAB_N; i++) begin
                sub_o[i]  <= '0;
                pre0_o[i] <= '0;
                pre1_o[i] <= '0;
            end
        end else if (!done_o) begin
            if (cnt_q == AT_SUB)  sub_o[idx_q]  <= cur_q;
            if (cnt_q == AT_PRE0) pre0_o[idx_q] <= cur_q[7:0];
            if (cnt_q == AT_PRE1) begin
                pre1_o[idx_q] <= cur_q[7:0];
                if (idx_q == LAST) begin
                    done_o <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    cur_q <= SEED_LIST[(int'(idx_q) + 1) * LFSR_W +: LFSR_W];
                    cnt_q <= '0;
                end
            end else begin
                cur_q <= lfsr_next(cur_q);
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nand_rnd_locate.sv
module nand_rnd_locate
    import nand_rnd_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int ECC_SIZE    = 512,
    parameter int ECC_BYTES   = 8,
    parameter int PREPAD      = 2,
    parameter int COL_W       = 12
) (
    input  logic [COL_W-1:0] col_i,
    input  layout_e          layout_i,
    output logic [COL_W-1:0] offs_o,
    output logic [COL_W:0]   left_o,
    output logic             use_sub_o,
    output logic             in_grp_o
);
    localparam int TOTAL    = PAGE_BYTES + SPARE_BYTES;
    localparam int NCHUNK   = PAGE_BYTES / ECC_SIZE;
    localparam int GRP      = ECC_BYTES + 4;
    localparam int UNIT     = ECC_SIZE + PREPAD + ECC_BYTES;
    localparam int GRP_END  = PAGE_BYTES + NCHUNK * GRP;
    localparam int UNIT_END = NCHUNK * UNIT;

    int c, cg, cu;
    assign c  = int'(col_i);
    assign cg = (c - PAGE_BYTES) % GRP;
    assign cu = c % UNIT;

    always_comb begin
        offs_o    = COL_W'(c % 4096);
        left_o    = (c < TOTAL) ? (COL_W+1)'(TOTAL - c) : '1;
        use_sub_o = 1'b0;
        in_grp_o  = 1'b0;
        case (layout_i)
            LAY_CHUNK: begin
                if (c < PAGE_BYTES) begin
                    offs_o = COL_W'(c % ECC_SIZE);
                    left_o = (COL_W+1)'(ECC_SIZE - c % ECC_SIZE);
                end else if (c < GRP_END) begin
                    offs_o    = COL_W'(cg);
                    left_o    = (COL_W+1)'(GRP - cg);
                    use_sub_o = 1'b1;
                    in_grp_o  = 1'b1;
                end
            end
            LAY_INTER: begin
                if (c < UNIT_END) begin
                    if (cu < ECC_SIZE) begin
                        offs_o = COL_W'(cu);
                        left_o = (COL_W+1)'(ECC_SIZE - cu);
                    end else begin
                        offs_o    = COL_W'(cu - ECC_SIZE);
                        left_o    = (COL_W+1)'(UNIT - cu);
                        use_sub_o = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_page_randomizer.sv
module nand_page_randomizer
    import nand_rnd_pkg::*;
#(
    parameter int PAGE_W      = 16,
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int ECC_SIZE    = 512,
    parameter int ECC_BYTES   = 8,
    parameter int PREPAD      = 2,
    parameter int NUM_SEEDS   = 1,
    parameter logic [NUM_SEEDS*LFSR_W-1:0] SEED_LIST = 15'h4A80,
    parameter int SUB_STEPS   = 4096,
    parameter int COL_W       = $clog2(PAGE_BYTES + SPARE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [COL_W-1:0]  column_i,
    input  logic              write_i,
    input  logic [1:0]        layout_i,
    input  logic              enable_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [7:0]        out_data_o
);
    localparam int IDX_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;
    localparam int TAB_N = 1 << IDX_W;

    rnd_state_e       st_q, st_d;
    lfsr_t            lfsr_q;
    logic [COL_W-1:0] seek_cnt_q, col_q, pos_q;
    logic [COL_W:0]   left_q;
    logic [IDX_W-1:0] idx_q;
    logic             wr_q, grp_q;
    layout_e          lay_q;

    logic             seeds_done;
    lfsr_t            sub_tab  [TAB_N];
    logic [7:0]       pre0_tab [TAB_N];
    logic [7:0]       pre1_tab [TAB_N];

    nand_rnd_seedtab #(
        .NUM_SEEDS(NUM_SEEDS), .SEED_LIST(SEED_LIST), .SUB_STEPS(SUB_STEPS),
        .IDX_W(IDX_W), .TAB_N(TAB_N)
    ) u_seedtab (
        .clk(clk), .rst_n(rst_n), .done_o(seeds_done),
        .sub_o(sub_tab), .pre0_o(pre0_tab), .pre1_o(pre1_tab)
    );

    // Segment lookup for either the new start column or the next column.
    logic             start_ok;
    logic [COL_W-1:0] loc_col, loc_offs;
    logic [COL_W:0]   loc_left;
    logic             loc_sub, loc_grp;
    layout_e          loc_lay;
    logic [IDX_W-1:0] new_idx, sel_idx;
    lfsr_t            loc_base;

    assign start_ok = start_i && (st_q != ST_INIT);
    assign loc_col  = start_i ? column_i : col_q + 1'b1;
    assign loc_lay  = start_i ? layout_e'(layout_i) : lay_q;
    assign new_idx  = IDX_W'(32'(page_i) % NUM_SEEDS);
    assign sel_idx  = start_i ? new_idx : idx_q;
    assign loc_base = loc_sub ? sub_tab[sel_idx]
                              : SEED_LIST[int'(sel_idx) * LFSR_W +: LFSR_W];

    nand_rnd_locate #(
        .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES), .ECC_SIZE(ECC_SIZE),
        .ECC_BYTES(ECC_BYTES), .PREPAD(PREPAD), .COL_W(COL_W)
    ) u_locate (
        .col_i(loc_col), .layout_i(loc_lay), .offs_o(loc_offs),
        .left_o(loc_left), .use_sub_o(loc_sub), .in_grp_o(loc_grp)
    );

    logic       accept, run_byte, reseed;
    logic [7:0] mask;

    assign in_ready_o = (st_q == ST_IDLE) || (st_q == ST_RUN);
    assign accept     = in_valid_i && in_ready_o && !start_i;
    assign run_byte   = accept && enable_i && (st_q == ST_RUN);
    assign reseed     = run_byte && (left_q == (COL_W+1)'(1));
    assign mask       = (wr_q && grp_q && pos_q < COL_W'(2))
                        ? ((pos_q == '0) ? pre0_tab[idx_q] : pre1_tab[idx_q])
                        : lfsr_q[7:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_INIT;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INIT: if (seeds_done) st_d = ST_IDLE;
            ST_IDLE: if (start_i) st_d = (loc_offs == '0) ? ST_RUN : ST_SEEK;
            ST_SEEK: begin
                if (start_i)                        st_d = (loc_offs == '0) ? ST_RUN : ST_SEEK;
                else if (seek_cnt_q == COL_W'(1))   st_d = ST_RUN;
            end
            ST_RUN: begin
                if (start_i || reseed) st_d = (loc_offs == '0) ? ST_RUN : ST_SEEK;
            end
        endcase
    end

    // Generator, segment tracking and output byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q      <= '0;
            seek_cnt_q  <= '0;
            col_q       <= '0;
            pos_q       <= '0;
            left_q      <= '0;
            idx_q       <= '0;
            wr_q        <= 1'b0;
            grp_q       <= 1'b0;
            lay_q       <= LAY_FLAT;
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= accept;
            if (accept) out_data_o <= run_byte ? (in_data_i ^ mask) : in_data_i;

            if (start_ok || reseed) begin
                if (start_ok) begin
                    idx_q <= new_idx;
                    wr_q  <= write_i;
                    lay_q <= layout_e'(layout_i);
                end
                col_q      <= loc_col;
                lfsr_q     <= loc_base;
                seek_cnt_q <= loc_offs;
                pos_q      <= loc_offs;
                left_q     <= loc_left;
                grp_q      <= loc_grp;
            end else if (st_q == ST_SEEK) begin
                lfsr_q     <= lfsr_next(lfsr_q);
                seek_cnt_q <= seek_cnt_q - 1'b1;
            end else if (run_byte) begin
                lfsr_q <= lfsr_next(lfsr_q);
                col_q  <= col_q + 1'b1;
                pos_q  <= pos_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nand_rnd_checker.sv
module nand_rnd_checker
    import nand_rnd_pkg::*;
#(
    parameter int COL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             enable_i,
    input logic             in_valid_i,
    input logic [7:0]       in_data_i,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic [7:0]       out_data_o,
    input rnd_state_e       st_q,
    input logic [COL_W-1:0] seek_cnt_q,
    input logic [COL_W:0]   left_q,
    input lfsr_t            lfsr_q,
    input logic             seeds_done
);
    logic run_byte;
    assign run_byte = in_valid_i && in_ready_o && !start_i && enable_i && (st_q == ST_RUN);

    assert_out_follows_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i && in_ready_o && !start_i));

    assert_bypass_when_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !$past(enable_i)) |-> (out_data_o == $past(in_data_i)));

    assert_seek_counts_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEEK && !start_i) |=>
            (st_q == ST_RUN || seek_cnt_q == $past(seek_cnt_q) - 1'b1));

    assert_lfsr_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_byte && left_q != (COL_W+1)'(1)) |=> (lfsr_q == lfsr_next($past(lfsr_q))));

    assert_ready_after_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> seeds_done);

    assert_segment_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (left_q != '0));
endmodule

bind nand_page_randomizer nand_rnd_checker #(.COL_W(COL_W)) u_rnd_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .enable_i(enable_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .st_q(st_q),
    .seek_cnt_q(seek_cnt_q), .left_q(left_q), .lfsr_q(lfsr_q),
    .seeds_done(seeds_done)
);

// File: tb/nand_page_randomizer_test.sv
`timescale 1ns/1ps
module nand_page_randomizer_test;
    localparam int PAGE = 64, SPARE = 40, ES = 16, EB = 4, PP = 2, NS = 3, SUBN = 4096;
    localparam int GRP = EB + 4, UNIT = ES + PP + EB;
    localparam int COLW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, wr = 1'b0, en = 1'b1, in_valid = 1'b0;
    logic [15:0] page = '0;
    logic [COLW-1:0] col = '0;
    logic [1:0] lay = '0;
    logic [7:0] in_data = '0;
    logic in_ready, out_valid;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    nand_page_randomizer #(
        .PAGE_BYTES(PAGE), .SPARE_BYTES(SPARE), .ECC_SIZE(ES), .ECC_BYTES(EB),
        .PREPAD(PP), .NUM_SEEDS(NS), .SEED_LIST({15'h7001, 15'h1234, 15'h4A80}),
        .SUB_STEPS(SUBN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .page_i(page), .column_i(col),
        .write_i(wr), .layout_i(lay), .enable_i(en), .in_valid_i(in_valid),
        .in_data_i(in_data), .in_ready_o(in_ready), .out_valid_o(out_valid),
        .out_data_o(out_data)
    );

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic [14:0] seeds [NS];
    logic [14:0] subs  [NS];

    function automatic logic [14:0] adv(logic [14:0] s, int n);
        for (int k = 0; k < n; k++) s = {s[0] ^ s[1], s[14:1]};
        return s;
    endfunction

    // Reference segment rule per column: offset, base choice, spare-group flag, tag.
    function automatic void where(input int c, input int l, output int off,
                                  output bit s, output bit g, output string t);
        int o;
        off = c % 4096; s = 0; g = 0; t = "R3";
        if (l == 1) begin
            if (c < PAGE) begin off = c % ES; t = "R4"; end
            else if (c < PAGE + (PAGE / ES) * GRP) begin
                off = (c - PAGE) % GRP; s = 1; g = 1; t = "R5";
            end
        end else if (l == 2 && c < (PAGE / ES) * UNIT) begin
            o = c % UNIT; t = "R6";
            if (o < ES) off = o;
            else begin off = o - ES; s = 1; end
        end
    endfunction

    task automatic chk(bit ok, string t, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (out_valid) begin
            if (exp_q.size() == 0) chk(0, "R12", out_data, -1);
            else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(out_data == e, t, out_data, e);
            end
        end
    endtask

    task automatic session(int pg, int c0, bit w, int l, int n, bit gaps, bit poke);
        int off, busy, i, mc;
        bit s, g;
        string t;
        logic [14:0] base;
        logic [7:0] m;
        page = 16'(pg); col = COLW'(c0); wr = w; lay = 2'(l); start = 1'b1; in_valid = 1'b0;
        tick();
        start = 1'b0;
        where(c0, l, off, s, g, t);
        busy = 0;
        while (!in_ready && busy < 5000) begin
            in_valid = poke; in_data = 8'hA5;
            tick();
            busy++;
        end
        chk(busy == off, "R9", busy, off);
        mc = c0; i = 0;
        while (i < n) begin
            en = !(gaps && (i % 4 == 2));
            in_valid = 1'b1; in_data = 8'($urandom);
            if (in_ready) begin
                if (!en) begin
                    exp_q.push_back(in_data); tag_q.push_back("R11");
                end else begin
                    where(mc, l, off, s, g, t);
                    base = s ? subs[pg % NS] : seeds[pg % NS];
                    if (w && g && off < 2) begin
                        m = adv(base, 15 + off) & 15'hFF; t = "R8";
                    end else m = adv(base, off) & 15'hFF;
                    if (mc != c0 && off == 0) t = {t, " R10"};
                    exp_q.push_back(in_data ^ m); tag_q.push_back(t);
                    mc++;
                end
                i++;
            end
            tick();
        end
        in_valid = 1'b0; en = 1'b1;
        tick(); tick();
        chk(exp_q.size() == 0, "R12", exp_q.size(), 0);
    endtask

    initial begin
        int wait_n;
        seeds[0] = 15'h4A80; seeds[1] = 15'h1234; seeds[2] = 15'h7001;
        for (int k = 0; k < NS; k++) subs[k] = adv(seeds[k], SUBN);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R7", in_ready, 0);
        chk(out_valid == 1'b0, "R12", out_valid, 0);
        wait_n = 0;
        while (!in_ready && wait_n < 20000) begin tick(); wait_n++; end
        chk(wait_n >= NS * SUBN, "R7", wait_n, NS * SUBN);
        // Idle passthrough before any session
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1; in_data = 8'(8'h3C + k);
            exp_q.push_back(in_data); tag_q.push_back("R13");
            tick();
        end
        in_valid = 1'b0; tick(); tick();
        session(0, 0, 0, 0, 20, 0, 0);     // R1 R2 R3, default seed entry
        session(4, 37, 0, 0, 20, 0, 1);    // R9 seek with offered bytes dropped
        session(2, 10, 0, 1, 60, 0, 0);    // R4 R5 R10 chunk and group boundaries
        session(1, 60, 1, 1, 40, 0, 1);    // R8 write masks, group-to-flat reseed
        session(1, 60, 0, 1, 12, 0, 0);    // R8 read side uses plain sub-seed
        session(5, 0, 0, 2, 100, 0, 1);    // R6 interleaved, unit-to-flat reseed
        session(3, 12, 1, 2, 30, 0, 0);    // R6 write has no special masks
        session(7, 5, 0, 0, 16, 1, 0);     // R11 enable gaps
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule